// File: doc/BRIEF.md
# Segmented Vector Pipeline Delay Line

This block delays a vector of parallel samples by a fixed whole number of clock cycles. It is used to line up one datapath branch with another branch that has a deeper pipeline. Every lane of the packed input vector is shifted through its own copy of the same chain, so all lanes leave the block together, exactly `LATENCY` advancing cycles after they entered.

The chain is built from segments. Each segment is an addressless run of shift stages that ends in a single output flip-flop. A segment never spans more than 33 cycles, so longer delays are made by chaining segments one after another.

A synchronous reset clears every stage to zero, and reset wins over enable. A clock enable freezes the whole chain. A latency of zero turns the block into a plain wire. That setting is refused at elaboration when the enable is built in.

Top module: `vec_delay_line`

## Requirements
- R1: A value on `dataIn` reaches `dataOut` unchanged after exactly `LATENCY` clock edges at which the chain advances.
- R2: The block carries `LANES` lanes, and lane k sits at bits `[k*WIDTH +: WIDTH]` of both the input and the output. Every lane has the same latency, and the lanes do not interact.
- R3: With `LATENCY` = 0 the output equals the input in the same cycle, and `rst` and `en` have no effect. `LATENCY` = 0 together with `HAS_ENABLE` = 1 is an elaboration error.
- R4: With `LATENCY` = 1 the output is the input registered once on each advancing edge.
- R5: The chain consists of ceil(`LATENCY`/33) segments. Each segment except the last is 33 cycles deep, and the last takes the remainder, so delays of 33, 34 and 64 each meet R1.
- R6: `rst` = 1 at a clock edge (when `HAS_RESET` = 1) clears every stage, and `dataOut` is zero after that edge.
- R7: `rst` takes precedence over `en`. With both high, the chain is cleared and no input is captured.
- R8: With `en` = 0 and `rst` = 0 (when `HAS_ENABLE` = 1), no stage changes. `dataOut` stays stable and no stored sample is lost or duplicated.
- R9: After a reset, `dataOut` stays zero until the first sample captured after the reset has travelled through all `LATENCY` stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous clear, active high; ignored when `HAS_RESET` = 0 |
| en | input | 1 | Advance enable, active high; ignored when `HAS_ENABLE` = 0 |
| dataIn | input | LANES*WIDTH | Packed input vector |
| dataOut | output | LANES*WIDTH | Packed input vector delayed by `LATENCY` cycles |

## Verification
A corrupted or stuck stage inside the chain does not show at the ports right away. It shows on `dataOut` only when the damaged sample reaches the last segment, up to `LATENCY` advancing cycles later. For this reason the bench keeps random, distinct per-lane data flowing long enough to fill every segment several times. A stage that ignores the clear or the hold shows within one cycle as a nonzero output after reset or as output movement while stalled. A segment with the wrong depth shows as a constant slip against the reference queue for every sample that follows.

// File: rtl/vdl_pkg.sv
package vdl_pkg;
  localparam int SEG_SPAN = 33;

  typedef struct packed {
    logic clear;
    logic advance;
  } vdl_ctrl_t;

  function automatic int segCount(input int lat);
    return (lat + SEG_SPAN - 1) / SEG_SPAN;
  endfunction

  function automatic int segDepth(input int lat, input int idx);
    int n;
    n = segCount(lat);
    return (idx < n - 1) ? SEG_SPAN : lat - SEG_SPAN * (n - 1);
  endfunction
endpackage

// File: rtl/vdl_ctrl.sv
module vdl_ctrl
  import vdl_pkg::*;
#(
  parameter bit HAS_ENABLE = 1'b1,
  parameter bit HAS_RESET  = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  output vdl_ctrl_t ctrl
);
  logic rstEff;
  logic enEff;

  assign rstEff = HAS_RESET ? rst : 1'b0;
  assign enEff  = HAS_ENABLE ? en : 1'b1;

  always_comb begin
    ctrl.clear   = rstEff;
    ctrl.advance = enEff && !rstEff;
  end

  generate
    if (HAS_RESET) begin : g_rstChk
      // R7: a reset cycle never lets data advance
      p_reset_blocks_shift_r7 : assert property (@(posedge clk) rst |-> !ctrl.advance)
        else $error("reset cycle advanced the chain");
    end
  endgenerate
endmodule

// File: rtl/vdl_segment.sv
module vdl_segment
  import vdl_pkg::*;
#(
  parameter int VW    = 32,
  parameter int DEPTH = 33
) (
  input  logic          clk,
  input  vdl_ctrl_t     ctrl,
  input  logic [VW-1:0] segIn,
  output logic [VW-1:0] segOut
);
  localparam int SRL_LEN = DEPTH - 1;

  logic [VW-1:0] outReg;
  logic [VW-1:0] feed;

  generate
    if (SRL_LEN == 0) begin : g_noSrl
      assign feed = segIn;
    end else begin : g_srl
      logic [VW-1:0] stage [SRL_LEN];
      always_ff @(posedge clk) begin
        if (ctrl.clear) begin
          for (int i = 0; i < SRL_LEN; i++) stage[i] <= '0;
        end else if (ctrl.advance) begin
          stage[0] <= segIn;
          for (int i = 1; i < SRL_LEN; i++) stage[i] <= stage[i-1];
        end
      end
      assign feed = stage[SRL_LEN-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ctrl.clear)        outReg <= '0;
    else if (ctrl.advance) outReg <= feed;
  end

  assign segOut = outReg;

  // R8: a stalled segment keeps its terminating register
  p_seg_hold_r8 : assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.advance |=> $stable(segOut))
    else $error("segment output moved while stalled");
endmodule

// File: rtl/vdl_datapath.sv
module vdl_datapath
  import vdl_pkg::*;
#(
  parameter int VW      = 32,
  parameter int LATENCY = 34
) (
  input  logic          clk,
  input  vdl_ctrl_t     ctrl,
  input  logic [VW-1:0] dpIn,
  output logic [VW-1:0] dpOut
);
  localparam int NSEG = segCount(LATENCY);

  generate
    if (LATENCY == 0) begin : g_wire
      assign dpOut = dpIn;
    end else begin : g_chain
      logic [VW-1:0] link [NSEG+1];
      assign link[0] = dpIn;
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
        vdl_segment #(.VW(VW), .DEPTH(segDepth(LATENCY, s))) u_seg (
          .clk   (clk),
          .ctrl  (ctrl),
          .segIn (link[s]),
          .segOut(link[s+1])
        );
      end
      assign dpOut = link[NSEG];

      // R6: a clear leaves the output at zero on the following cycle
      p_clear_zero_r6 : assert property (@(posedge clk) ctrl.clear |=> dpOut == '0)
        else $error("output not zero after clear");
      // R8: whole chain frozen while not advancing
      p_hold_out_r8 : assert property (@(posedge clk) disable iff (ctrl.clear)
        !ctrl.advance |=> $stable(dpOut))
        else $error("output moved during stall");
      if (LATENCY == 1) begin : g_oneChk
        // R4: single stage registers the input once
        p_single_stage_r4 : assert property (@(posedge clk) disable iff (ctrl.clear)
          ctrl.advance |=> dpOut == $past(dpIn))
          else $error("single-stage delay wrong");
      end
    end
  endgenerate
endmodule

// File: rtl/vec_delay_line.sv
module vec_delay_line
  import vdl_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int WIDTH      = 8,
  parameter int LATENCY    = 34,
  parameter bit HAS_ENABLE = 1'b1,
  parameter bit HAS_RESET  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [LANES*WIDTH-1:0] dataIn,
  output logic [LANES*WIDTH-1:0] dataOut
);
  localparam int VW = LANES * WIDTH;

  generate
    if (LATENCY < 0 || (LATENCY == 0 && HAS_ENABLE)) begin : g_badCfg
      $error("zero latency is not allowed with the enable built in");
    end
  endgenerate

  vdl_ctrl_t ctrl;

  vdl_ctrl #(.HAS_ENABLE(HAS_ENABLE), .HAS_RESET(HAS_RESET)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .ctrl(ctrl)
  );

  vdl_datapath #(.VW(VW), .LATENCY(LATENCY)) u_dp (
    .clk  (clk),
    .ctrl (ctrl),
    .dpIn (dataIn),
    .dpOut(dataOut)
  );
endmodule

// File: tb/vec_delay_line_tb.sv
`timescale 1ns/1ps
module vec_delay_line_tb;
  localparam int LANES = 4;
  localparam int WIDTH = 8;
  localparam int VW    = LANES * WIDTH;
  localparam int NCFG  = 5;
  localparam int LATS [NCFG] = '{0, 1, 33, 34, 64};

  typedef logic [VW-1:0] vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  vec_t din = '0;
  vec_t douts [NCFG];

  vec_t refQ [NCFG][$];
  int   nCheck = 0;
  int   nFail  = 0;
  string phaseTag = "R6";

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    vec_delay_line #(
      .LANES(LANES), .WIDTH(WIDTH), .LATENCY(LATS[g]),
      .HAS_ENABLE(LATS[g] != 0), .HAS_RESET(1'b1)
    ) u_dut (
      .clk(clk), .rst(rst), .en(en), .dataIn(din), .dataOut(douts[g])
    );
  end

  function automatic string cfgTag(int c);
    if (c == 0) return "R3";
    if (c == 1) return "R4";
    return "R5";
  endfunction

  task automatic clearModel();
    for (int c = 1; c < NCFG; c++) begin
      refQ[c].delete();
      for (int k = 0; k < LATS[c]; k++) refQ[c].push_back('0);
    end
  endtask

  // driver side of the scoreboard: capture on every edge
  always @(posedge clk) begin
    for (int c = 1; c < NCFG; c++) begin
      if (rst) begin
        refQ[c].delete();
        for (int k = 0; k < LATS[c]; k++) refQ[c].push_back('0);
      end else if (en) begin
        refQ[c].push_back(din);
        void'(refQ[c].pop_front());
      end
    end
  end

  task automatic compare(int c, vec_t act, vec_t exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s L=%0d actual=%h expected=%h at %0t",
               phaseTag, cfgTag(c), LATS[c], act, exp, $time);
    end
  endtask

  // monitor: compare registered configs at the falling edge
  task automatic checkRegistered();
    for (int c = 1; c < NCFG; c++) compare(c, douts[c], refQ[c][0]);
  endtask

  task automatic cycle(logic r, logic e, vec_t d);
    @(negedge clk);
    checkRegistered();
    rst = r; en = e; din = d;
    #1;
    compare(0, douts[0], din); // R3 combinational pass-through
  endtask

  function automatic vec_t rndVec();
    vec_t v;
    for (int l = 0; l < LANES; l++) v[l*WIDTH +: WIDTH] = WIDTH'($urandom);
    return v;
  endfunction

  task automatic runAll();
    clearModel();
    phaseTag = "R6";
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, rndVec());
    phaseTag = "R9";
    for (int i = 0; i < 70; i++) cycle(1'b0, 1'b1, rndVec());
    phaseTag = "R1 R2";
    for (int i = 0; i < 100; i++) cycle(1'b0, 1'b1, rndVec());
    phaseTag = "R8";
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0, rndVec());
    phaseTag = "R1 R2";
    for (int i = 0; i < 200; i++) cycle(1'b0, ($urandom % 10) < 7, rndVec());
    phaseTag = "R7";
    for (int i = 0; i < 2; i++) cycle(1'b1, 1'b1, rndVec());
    phaseTag = "R9";
    for (int i = 0; i < 70; i++) cycle(1'b0, 1'b1, rndVec());
    phaseTag = "R6";
    for (int i = 0; i < 300; i++)
      cycle(($urandom % 20) == 0, ($urandom % 4) != 0, rndVec());
    @(negedge clk);
    checkRegistered();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        nCheck++;
        nFail++;
        $display("FAIL watchdog expired at %0t", $time);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end
endmodule